// File: doc/BRIEF.md
# Priority Level Bus Arbiter

This block decides which of three masters owns a shared on-chip bus. Two of the masters have fixed standing. The system-integration master outranks every programmable level. The processor core ranks below all of them. The third master, a DMA engine, takes its standing from a small programmable level value. Only the values strictly inside the level range are legal for it. The two end values are rejected, and while one of them is programmed the DMA request is dropped from arbitration.

A new owner is chosen only while the bus is idle, so a transfer that is in progress always completes first. When no other master asks for the bus, ownership parks on the processor core. Exactly one grant line is high in every cycle.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is held low at a clock edge, the grant becomes the core grant. The grant vector uses bit 2 for the system master, bit 1 for the DMA master and bit 0 for the core, so the reset value is 3'b001.
- R2: Exactly one bit of `grant` is high in every cycle after reset.
- R3: If `sys_req` is high and `bus_busy` is low at a clock edge, `grant` becomes 3'b100 after that edge, whatever the DMA request and level are.
- R4: If `sys_req` is low, `dma_req` is high, the DMA level is legal and `bus_busy` is low at a clock edge, `grant` becomes 3'b010 after that edge.
- R5: `level_err` is high, combinationally, exactly when `dma_level` is all zeros or all ones (0 or 7 for a 3-bit level).
- R6: While `level_err` is high, `dma_req` is ignored. With `sys_req` low and the bus idle, the grant goes to the core (3'b001).
- R7: While `bus_busy` is high at a clock edge, `grant` keeps its value across that edge.
- R8: If neither `sys_req` nor `dma_req` is high and the bus is idle, `grant` parks on the core (3'b001).
- R9: A change of the request inputs is seen on `grant` one clock edge later, and no sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_req | input | 1 | Bus request from the system-integration master |
| dma_req | input | 1 | Bus request from the DMA master |
| dma_level | input | LVL_W | Programmed arbitration level of the DMA master |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| grant | output | 3 | One-hot grant: bit 2 system, bit 1 DMA, bit 0 core |
| level_err | output | 1 | DMA level is set to an illegal end value |

## Verification
The bench builds the block with the default 3-bit level, so all eight level values are within reach. It sweeps every level against every combination of the two requests and the busy input. Because the sweep runs as one continuous sequence, each busy cycle is tested while holding grants left by different earlier winners. A second pass drives pseudo-random sequences drawn from the same space. This covers transitions between all three owners, including moves straight from a DMA grant to a blocked level.

// File: rtl/arb_pkg.sv
// Package: shared constants for the priority level bus arbiter.
// Assumes exactly three masters; the index order fixes the grant bit positions.
package arb_pkg;
    localparam int NUM_M    = 3;
    localparam int SYS_IDX  = 2;
    localparam int DMA_IDX  = 1;
    localparam int CORE_IDX = 0;
endpackage

// File: rtl/arb_level_check.sv
// Module: arb_level_check
// Flags a DMA level that sits at either end of the programmable range.
// Assumes the level is an unsigned value of LVL_W bits.
module arb_level_check #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] level,
    output logic             bad
);
    localparam logic [LVL_W-1:0] LOW_END  = '0;
    localparam logic [LVL_W-1:0] HIGH_END = '1;

    // Purpose: compare the level against both reserved end values.
    always_comb begin
        bad = (level == LOW_END) || (level == HIGH_END);
    end
endmodule

// File: rtl/arb_rank_pick.sv
// Module: arb_rank_pick
// Returns a one-hot vector marking the requester with the highest rank.
// Assumes ranks of live requesters are distinct; on a tie the lowest index wins.
module arb_rank_pick #(
    parameter int NUM_M  = 3,
    parameter int RANK_W = 4
) (
    input  logic [NUM_M-1:0]        req,
    input  logic [NUM_M*RANK_W-1:0] rank_flat,
    output logic [NUM_M-1:0]        win
);
    logic [RANK_W-1:0] best;
    logic              found;

    // Purpose: linear scan keeping the best rank seen among live requesters.
    always_comb begin
        win   = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_M; i++) begin
            if (req[i] && (!found || (rank_flat[i*RANK_W +: RANK_W] > best))) begin
                best   = rank_flat[i*RANK_W +: RANK_W];
                win    = '0;
                win[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_grant_reg.sv
// Module: arb_grant_reg
// Holds the current one-hot grant and loads a new one only when not held.
// Assumes next is one-hot; reset parks the grant on PARK_IDX.
module arb_grant_reg #(
    parameter int NUM_M    = 3,
    parameter int PARK_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [NUM_M-1:0] next,
    output logic [NUM_M-1:0] grant
);
    localparam logic [NUM_M-1:0] PARK_VEC = NUM_M'(1) << PARK_IDX;

    // Purpose: register the grant, changing it only at idle bus boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= PARK_VEC;
        end else if (!hold) begin
            grant <= next;
        end
    end
endmodule

// File: rtl/prio_bus_arbiter.sv
// Module: prio_bus_arbiter (top)
// Grants the bus to the system master, the DMA master or the core by rank.
// The system master ranks above every programmable level, and the core ranks
// below level 0. The DMA rank is its level plus one. A DMA level at either end
// of the range is illegal and masks the DMA request. The grant changes only
// while bus_busy is low.
module prio_bus_arbiter #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_req,
    input  logic             dma_req,
    input  logic [LVL_W-1:0] dma_level,
    input  logic             bus_busy,
    output logic [2:0]       grant,
    output logic             level_err
);
    import arb_pkg::*;

    localparam int RANK_W = LVL_W + 1;

    logic                    lvl_bad;
    logic [NUM_M-1:0]        eff_req;
    logic [NUM_M*RANK_W-1:0] rank_flat;
    logic [NUM_M-1:0]        winner;

    arb_level_check #(.LVL_W(LVL_W)) u_lvl (
        .level (dma_level),
        .bad   (lvl_bad)
    );

    // One rank slot and one request line per master, chosen by index.
    for (genvar m = 0; m < NUM_M; m++) begin : g_master
        if (m == SYS_IDX) begin : g_sys
            assign rank_flat[m*RANK_W +: RANK_W] = RANK_W'(1) << LVL_W;
            assign eff_req[m] = sys_req;
        end else if (m == DMA_IDX) begin : g_dma
            assign rank_flat[m*RANK_W +: RANK_W] = RANK_W'(dma_level) + RANK_W'(1);
            assign eff_req[m] = dma_req && !lvl_bad;
        end else begin : g_core
            assign rank_flat[m*RANK_W +: RANK_W] = '0;
            assign eff_req[m] = 1'b1;
        end
    end

    arb_rank_pick #(.NUM_M(NUM_M), .RANK_W(RANK_W)) u_pick (
        .req       (eff_req),
        .rank_flat (rank_flat),
        .win       (winner)
    );

    arb_grant_reg #(.NUM_M(NUM_M), .PARK_IDX(CORE_IDX)) u_greg (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (bus_busy),
        .next  (winner),
        .grant (grant)
    );

    assign level_err = lvl_bad;
endmodule

// File: rtl/arb_checks.sv
// Module: arb_checks
// Protocol checks for prio_bus_arbiter, attached through bind.
module arb_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_req,
    input logic       dma_req,
    input logic       bus_busy,
    input logic [2:0] grant,
    input logic       level_err
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1); // R2
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable(grant)); // R7
    AST_SYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && sys_req) |=> grant == 3'b100); // R3
    AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && !sys_req && dma_req && !level_err) |=> grant == 3'b010); // R4
    AST_BAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && !sys_req && level_err) |=> grant == 3'b001); // R6
    AST_PARK_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && !sys_req && !dma_req) |=> grant == 3'b001); // R8
endmodule

bind prio_bus_arbiter arb_checks u_arb_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_req   (sys_req),
    .dma_req   (dma_req),
    .bus_busy  (bus_busy),
    .grant     (grant),
    .level_err (level_err)
);

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 3;
    localparam int LVL_MAX    = (1 << LVL_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sys_req;
    logic             dma_req;
    logic [LVL_W-1:0] dma_level;
    logic             bus_busy;
    logic [2:0]       grant;
    logic             level_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [2:0] exp_g;

    prio_bus_arbiter #(.LVL_W(LVL_W)) i_prio_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .dma_req(dma_req),
        .dma_level(dma_level), .bus_busy(bus_busy), .grant(grant),
        .level_err(level_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_val(input string req, input logic [2:0] act, input logic [2:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, expv);
        end
    endtask

    // Drive one input combination, confirm the flag and the unchanged grant (R9),
    // then step one edge and confirm the new grant.
    task automatic step(input bit s, input bit d, input int l, input bit b);
        bit bad;
        bad = (l == 0) || (l == LVL_MAX);
        sys_req = s; dma_req = d; dma_level = LVL_W'(l); bus_busy = b;
        #1;
        check_val("R5 level_err", {2'b0, level_err}, {2'b0, bad});
        check_val("R9 no early change", grant, exp_g);
        if (!b) begin
            if (s)             exp_g = 3'b100; // R3
            else if (d && !bad) exp_g = 3'b010; // R4
            else               exp_g = 3'b001; // R6, R8
        end                                    // else R7 hold
        @(posedge clk); #1;
        check_val(b ? "R7 hold" : (s ? "R3 sys" : ((d && !bad) ? "R4 dma" :
                  (d ? "R6 bad level" : "R8 park"))), grant, exp_g);
        check_val("R2 one-hot", 3'($countones(grant)), 3'd1);
    endtask

    initial begin
        rst_n = 1'b0; sys_req = 1'b1; dma_req = 1'b1; dma_level = 3'd3; bus_busy = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_val("R1 reset grant", grant, 3'b001);
        rst_n = 1'b1;
        exp_g = 3'b001;
        for (int l = 0; l <= LVL_MAX; l++)
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 2; s++)
                    for (int d = 0; d < 2; d++) begin
                        step(1'(s), 1'(d), l, 1'(b));
                        step(1'(d), 1'(s), LVL_MAX - l, 1'(~b));
                    end
        begin
            logic [7:0] lf;
            lf = 8'hA5;
            for (int n = 0; n < 300; n++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                step(lf[0], lf[1], int'(lf[4:2]), lf[5] & lf[6]);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule